// File: doc/BRIEF.md
# Two-Channel DMA Terminal-Count Controller

This block keeps the transfer-count and control state of a two-channel DMA engine. Each channel carries a 16-bit down-counter and a small control word (arm, stop-at-terminal-count, interrupt enable, priority and pacing mode). A small state machine picks which eligible channel owns the bus. It then holds that grant until the datapath reports the transfer finished with a one-cycle done strobe. Each completed transfer lowers the owning channel's count by one. The channel's own rules then decide whether it disarms itself and whether it raises a sticky interrupt flag.

Software reaches the block through a four-address register port. Address 0 is the channel 0 count and address 1 is the channel 0 control word. Addresses 2 and 3 are the same two registers for channel 1. Control word bits are: [0] arm, [1] stop at terminal count, [2] interrupt enable, [3] high priority, [5:4] pacing mode, and [8] interrupt pending. Bit 8 reads the pending flag, and writing a 1 to it clears the flag. Pacing mode codes are 00 for free-running (software-started), 01 for source-paced, 10 for destination-paced and 11, which is also paced. Reads are combinational. The count register has no reset value.

The grant machine has two states. ARB_IDLE waits for a channel to be eligible. It takes the transition "grant" to ARB_BUSY on the clock edge after any channel becomes eligible, and latches the chosen channel. ARB_BUSY keeps the grant steady. It takes the transition "complete" back to ARB_IDLE on the edge where the done strobe is sampled.

Top module: `dma_tc_ctrl`

## Requirements
- R1: Every done strobe seen while a channel is granted lowers that channel's count by exactly one, on the following clock edge.
- R2: In a paced mode (01, 10, 11) with the stop bit (bit 1) set, the transfer that brings the count to zero clears the arm bit (bit 0), and that channel receives no further grants.
- R3: In a paced mode with the stop bit clear, the channel stays armed whatever its count holds, and a transfer at count zero wraps the count to 16'hFFFF.
- R4: In free-running mode (00) the channel disarms when its count reaches zero, whatever the stop bit says, and it is eligible without its request input.
- R5: A channel in a paced mode is granted only while its request input is high.
- R6: The pending flag (control bit 8, also the irq output) is set at terminal count only when both the stop bit and the interrupt enable (bit 2) are set. It stays set until software writes a 1 to bit 8.
- R7: When both channels are eligible and their priority bits (bit 3, 1 = high) differ, the high-priority channel is granted.
- R8: When both channels are eligible with equal priority, the channel granted most recently loses. After reset, channel 0 wins the first such contest.
- R9: Reset clears the arm and pending bits of both channels and puts the grant machine in ARB_IDLE with grant_valid low.
- R10: The grant machine moves from ARB_IDLE to ARB_BUSY one edge after a channel is eligible. It keeps grant_valid high and grant_ch steady until a done strobe, and then returns to ARB_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address: bit 1 selects the channel, bit 0 selects control (1) or count (0) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| xfer_req | input | 2 | Per-channel request inputs for paced modes |
| grant_valid | output | 1 | A channel owns the transfer slot |
| grant_ch | output | 1 | Index of the granted channel |
| xfer_done | input | 1 | One-cycle strobe: the granted transfer completed |
| irq | output | 2 | Per-channel sticky interrupt pending flags |

## Verification
The bench targets the edges of terminal count. A design that disarmed one transfer early or late would show a wrong number of grants. Ignoring the stop bit in paced mode would stop a channel that should wrap to 16'hFFFF, and honouring it in free-running mode would let that channel run past zero. The bench checks that interrupts appear only with both enable bits set and that the write-one clear works. A design that set pending on the stop bit alone would raise a spurious irq. For arbitration, the bench checks that a high-priority channel keeps winning and that equal priorities alternate starting from channel 0 after reset. A fixed-order arbiter would grant channel 0 twice in a row. The bench also holds off the done strobe and checks that the grant stays steady.

// File: rtl/dma_tc_pkg.sv
package dma_tc_pkg;

    typedef enum logic [1:0] {
        MODE_FREE  = 2'b00,
        MODE_SRC   = 2'b01,
        MODE_DST   = 2'b10,
        MODE_PACED = 2'b11
    } pace_mode_e;

    typedef struct packed {
        pace_mode_e mode;
        logic       high_pri;
        logic       irq_en;
        logic       tc_stop;
        logic       arm;
    } chan_ctl_t;

    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_BUSY = 1'b1
    } arb_state_e;

    localparam int CTL_W     = $bits(chan_ctl_t);
    localparam int PEND_BIT  = 8;

endpackage

// File: rtl/dma_tc_channel.sv
module dma_tc_channel
    import dma_tc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_wr_i,
    input  logic             ctl_wr_i,
    input  logic [CNT_W-1:0] cnt_wdata_i,
    input  chan_ctl_t        ctl_wdata_i,
    input  logic             pend_clr_i,
    input  logic             done_i,
    input  logic             dreq_i,
    output logic [CNT_W-1:0] cnt_o,
    output chan_ctl_t        ctl_o,
    output logic             pend_o,
    output logic             elig_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    chan_ctl_t        ctl_q;
    logic             pend_q;
    logic             hits_zero;
    logic             stop_rule;
    logic             free_run;

    assign free_run  = (ctl_q.mode == MODE_FREE);
    assign hits_zero = (cnt_q == ONE);
    assign stop_rule = ctl_q.tc_stop || free_run;

    // Count register: deliberately left without reset.
    always_ff @(posedge clk) begin
        if (cnt_wr_i) begin
            cnt_q <= cnt_wdata_i;
        end else if (done_i) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (ctl_wr_i) begin
                ctl_q <= ctl_wdata_i;
                if (pend_clr_i) begin
                    pend_q <= 1'b0;
                end
            end else if (done_i && hits_zero) begin
                if (stop_rule) begin
                    ctl_q.arm <= 1'b0;
                end
                if (ctl_q.tc_stop && ctl_q.irq_en) begin
                    pend_q <= 1'b1;
                end
            end
        end
    end

    assign elig_o = ctl_q.arm && (free_run || dreq_i);
    assign cnt_o  = cnt_q;
    assign ctl_o  = ctl_q;
    assign pend_o = pend_q;

    // R1
    dec_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !cnt_wr_i) |=> (cnt_q == $past(cnt_q) - ONE));

    // R2
    tc_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !ctl_wr_i && cnt_q == ONE && ctl_q.tc_stop) |=> !ctl_q.arm);

    // R4
    free_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !ctl_wr_i && cnt_q == ONE && ctl_q.mode == MODE_FREE) |=> !ctl_q.arm);

    // R3
    keep_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !ctl_wr_i && ctl_q.arm && !ctl_q.tc_stop && ctl_q.mode != MODE_FREE)
        |=> ctl_q.arm);

    // R6
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(ctl_q.tc_stop && ctl_q.irq_en && done_i));

endmodule

// File: rtl/dma_tc_arbiter.sv
module dma_tc_arbiter
    import dma_tc_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] elig_i,
    input  logic [NCH-1:0] high_pri_i,
    input  logic           done_i,
    output logic           grant_valid_o,
    output logic           grant_ch_o
);

    arb_state_e state_q;
    arb_state_e state_d;
    logic       grant_ch_q;
    logic       last_q;
    logic       pick;

    // Choice among eligible channels: priority first, then rotation.
    always_comb begin
        if (&elig_i) begin
            if (high_pri_i[0] != high_pri_i[1]) begin
                pick = high_pri_i[1];
            end else begin
                pick = ~last_q;
            end
        end else begin
            pick = elig_i[1];
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE: if (|elig_i) state_d = ARB_BUSY;
            ARB_BUSY: if (done_i)  state_d = ARB_IDLE;
            default:  state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ARB_IDLE;
            grant_ch_q <= 1'b0;
            last_q     <= 1'b1;
        end else begin
            state_q <= state_d;
            if (state_q == ARB_IDLE && |elig_i) begin
                grant_ch_q <= pick;
                last_q     <= pick;
            end
        end
    end

    always_comb begin
        grant_valid_o = (state_q == ARB_BUSY);
        grant_ch_o    = grant_ch_q;
    end

    // R10
    idle_to_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_IDLE && |elig_i) |=> (state_q == ARB_BUSY));

    // R10
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_BUSY && !done_i) |=> (state_q == ARB_BUSY && $stable(grant_ch_q)));

    // R7
    high_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_IDLE && &elig_i && high_pri_i[0] != high_pri_i[1])
        |=> (grant_ch_q == $past(high_pri_i[1])));

    // R8
    rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_IDLE && &elig_i && high_pri_i[0] == high_pri_i[1])
        |=> (grant_ch_q != $past(last_q)));

endmodule

// File: rtl/dma_tc_ctrl.sv
module dma_tc_ctrl
    import dma_tc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    input  logic [1:0]       xfer_req,
    output logic             grant_valid,
    output logic             grant_ch,
    input  logic             xfer_done,
    output logic [1:0]       irq
);

    localparam int NCH = 2;

    logic [CNT_W-1:0] cnt_arr [NCH];
    chan_ctl_t        ctl_arr [NCH];
    logic [NCH-1:0]   pend;
    logic [NCH-1:0]   elig;
    logic [NCH-1:0]   hp;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic sel;
        logic ch_done;

        assign sel     = reg_wr && (reg_addr[1] == 1'(c));
        assign ch_done = xfer_done && grant_valid && (grant_ch == 1'(c));
        assign hp[c]   = ctl_arr[c].high_pri;

        dma_tc_channel #(.CNT_W(CNT_W)) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .cnt_wr_i    (sel && !reg_addr[0]),
            .ctl_wr_i    (sel && reg_addr[0]),
            .cnt_wdata_i (reg_wdata),
            .ctl_wdata_i (chan_ctl_t'(reg_wdata[CTL_W-1:0])),
            .pend_clr_i  (reg_wdata[PEND_BIT]),
            .done_i      (ch_done),
            .dreq_i      (xfer_req[c]),
            .cnt_o       (cnt_arr[c]),
            .ctl_o       (ctl_arr[c]),
            .pend_o      (pend[c]),
            .elig_o      (elig[c])
        );
    end

    dma_tc_arbiter #(.NCH(NCH)) u_arb (
        .clk           (clk),
        .rst_n         (rst_n),
        .elig_i        (elig),
        .high_pri_i    (hp),
        .done_i        (xfer_done),
        .grant_valid_o (grant_valid),
        .grant_ch_o    (grant_ch)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr[0]) begin
            reg_rdata[CTL_W-1:0] = ctl_arr[reg_addr[1]];
            reg_rdata[PEND_BIT]  = pend[reg_addr[1]];
        end else begin
            reg_rdata = cnt_arr[reg_addr[1]];
        end
    end

    assign irq = pend;

    // R9
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!grant_valid && irq == 2'b00));

endmodule

// File: tb/dma_tc_ctrl_test.sv
module dma_tc_ctrl_test;

    typedef struct packed {
        logic [15:0] cnt;
        logic        tc;
        logic        ie;
        logic [1:0]  mode;
        logic        dreq;
        logic [3:0]  n;
        logic [3:0]  grants;
        logic [15:0] exp_cnt;
        logic        exp_arm;
        logic        exp_irq;
    } vec_t;

    // cnt, tc, ie, mode, dreq, tries, grants, count after, arm after, irq after
    localparam vec_t VEC [6] = '{
        '{16'd3, 1'b1, 1'b0, 2'b01, 1'b1, 4'd5, 4'd3, 16'h0000, 1'b0, 1'b0},
        '{16'd2, 1'b1, 1'b1, 2'b10, 1'b1, 4'd4, 4'd2, 16'h0000, 1'b0, 1'b1},
        '{16'd2, 1'b0, 1'b1, 2'b01, 1'b1, 4'd4, 4'd4, 16'hFFFE, 1'b1, 1'b0},
        '{16'd2, 1'b0, 1'b1, 2'b00, 1'b0, 4'd4, 4'd2, 16'h0000, 1'b0, 1'b0},
        '{16'd4, 1'b1, 1'b0, 2'b01, 1'b0, 4'd3, 4'd0, 16'h0004, 1'b1, 1'b0},
        '{16'd1, 1'b1, 1'b0, 2'b00, 1'b0, 4'd3, 4'd1, 16'h0000, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'b00;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [1:0]  xfer_req = 2'b00;
    logic        grant_valid;
    logic        grant_ch;
    logic        xfer_done = 1'b0;
    logic [1:0]  irq;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    dma_tc_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_req(xfer_req),
        .grant_valid(grant_valid), .grant_ch(grant_ch), .xfer_done(xfer_done),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        xfer_req = 2'b00;
        xfer_done = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Wait for a grant, return its channel, complete it. Optionally drop requests with the strobe.
    task automatic take(input bit drop, output bit ok, output logic ch);
        ok = 1'b0;
        ch = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (grant_valid) begin
                ok = 1'b1;
                break;
            end
        end
        if (ok) begin
            ch = grant_ch;
            xfer_done = 1'b1;
            if (drop) xfer_req = 2'b00;
            @(negedge clk);
            xfer_done = 1'b0;
        end
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] d;
        bit ok;
        logic ch;
        int got;

        do_reset();
        @(negedge clk);
        // R9 reset state
        chk("R9 grant_valid", 32'(grant_valid), 0);
        chk("R9 irq", 32'(irq), 0);
        rd(2'd1, d); chk("R9 ch0 arm", 32'(d[0]), 0);
        rd(2'd3, d); chk("R9 ch1 arm", 32'(d[0]), 0);

        // Table walk on channel 0: R1..R6
        foreach (VEC[i]) begin
            xfer_req = 2'b00;
            wr(2'd0, VEC[i].cnt);
            wr(2'd1, {10'd0, VEC[i].mode, 1'b0, VEC[i].ie, VEC[i].tc, 1'b1});
            xfer_req[0] = VEC[i].dreq;
            got = 0;
            for (int t = 0; t < int'(VEC[i].n); t++) begin
                take(t == int'(VEC[i].n) - 1, ok, ch);
                if (!ok) break;
                got++;
                chk($sformatf("R2/R5 vec%0d grant channel", i), 32'(ch), 0);
            end
            xfer_req = 2'b00;
            @(negedge clk);
            chk($sformatf("R2/R4/R5 vec%0d grants", i), 32'(got), 32'(VEC[i].grants));
            rd(2'd0, d);
            chk($sformatf("R1/R3 vec%0d count", i), 32'(d), 32'(VEC[i].exp_cnt));
            rd(2'd1, d);
            chk($sformatf("R2/R3/R4 vec%0d arm", i), 32'(d[0]), 32'(VEC[i].exp_arm));
            chk($sformatf("R6 vec%0d pending bit", i), 32'(d[8]), 32'(VEC[i].exp_irq));
            chk($sformatf("R6 vec%0d irq", i), 32'(irq), {30'd0, 1'b0, VEC[i].exp_irq});
            wr(2'd1, 16'h0100);
            @(negedge clk);
            chk($sformatf("R6 vec%0d irq after clear", i), 32'(irq), 0);
        end

        // Priority: ch1 high, ch0 low (R7), plus grant hold (R10)
        do_reset();
        wr(2'd0, 16'd10);
        wr(2'd2, 16'd10);
        wr(2'd1, 16'h0011);
        wr(2'd3, 16'h0019);
        @(negedge clk);
        chk("R5 no grant without request", 32'(grant_valid), 0);
        xfer_req = 2'b11;
        @(negedge clk);
        @(negedge clk);
        chk("R10 busy one edge after eligible", 32'(grant_valid), 1);
        chk("R7 high priority first", 32'(grant_ch), 1);
        @(negedge clk);
        @(negedge clk);
        chk("R10 grant held without done", {31'd0, grant_valid}, 1);
        chk("R10 grant channel stable", 32'(grant_ch), 1);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        chk("R10 back to idle after done", 32'(grant_valid), 0);
        take(1'b1, ok, ch);
        chk("R7 high priority again", 32'(ch), 1);
        @(negedge clk);
        rd(2'd2, d); chk("R1 ch1 count", 32'(d), 8);
        rd(2'd0, d); chk("R1 ch0 count untouched", 32'(d), 10);
        wr(2'd1, 16'h0100);
        wr(2'd3, 16'h0100);

        // Rotation: equal priority (R8)
        do_reset();
        wr(2'd0, 16'd10);
        wr(2'd2, 16'd10);
        wr(2'd1, 16'h0011);
        wr(2'd3, 16'h0011);
        xfer_req = 2'b11;
        for (int g = 0; g < 4; g++) begin
            take(1'b0, ok, ch);
            chk($sformatf("R8 low-low rotation grant %0d", g), 32'(ch), 32'(g % 2));
        end
        xfer_req = 2'b00;
        @(negedge clk);
        if (grant_valid) begin
            xfer_done = 1'b1;
            @(negedge clk);
            xfer_done = 1'b0;
        end
        wr(2'd1, 16'h0019);
        wr(2'd3, 16'h0019);
        xfer_req = 2'b11;
        for (int g = 0; g < 2; g++) begin
            take(g == 1, ok, ch);
            chk($sformatf("R8 high-high rotation grant %0d", g), 32'(ch), 32'(g % 2));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule